// File: doc/BRIEF.md
# Aligned Chunk Fetch Buffer

This block sits between a single-ported instruction cache and a decode stage. Each fetch reads one naturally aligned chunk of eight 32-bit instructions. The valid part of the chunk goes into a 16-entry instruction queue, and decode receives up to five instructions per cycle in program order. Instructions that decode cannot take stay queued for later cycles.

On a redirect, every queued instruction and any chunk still in flight is discarded. The fetch pointer then moves to the target. The chunk holding the target is still read whole, but the slots before the target are trimmed away. A target in the last slot therefore yields a single useful instruction from that read.

A read is issued only when the queue can certainly absorb a full chunk. Because fetch is wider than decode, some cycles have no fetch, and those cycles can carry refill writes. A pending refill write always wins the cache port over a fetch.

Top module: `chunk_fetch_buffer`

## Requirements
- R1: Every cache read drives `port_addr` with its five low bits zero. The data returned on `port_rdata` in the following cycle carries the instruction at chunk base + 4k in bits [32k+31:32k], for k = 0..7.
- R2: After a redirect to a word-aligned target in slot s of its chunk, the first instruction offered to decode is the target, and no slot below s of that chunk is ever offered. In the first cycle that offers instructions, the number offered is min(8-s, 5).
- R3: `dec_valid` is contiguous from bit 0 and never exceeds five lanes. Lane 0 holds the oldest instruction, and each further valid lane holds the next sequential address (previous lane + 4).
- R4: While `dec_stall` is high, the offered instructions are held unchanged. In a cycle with `dec_stall` low, every offered instruction is consumed, and the remaining ones appear in the next cycle starting at lane 0.
- R5: While `refill_pending` is high, `port_wr` is high and `port_rd` is low in the same cycle.
- R6: The queue holds 16 instructions. A read is issued only when the queued count plus 8 for a chunk in flight is at most 8. With decode stalled from an empty queue, exactly two reads are issued and then none.
- R7: In a cycle with `redirect_valid` high, `dec_valid` is all zero and no read is issued. In the next cycle the queue is empty and any chunk in flight is dropped. Without a refill, the target is offered three cycles after the redirect cycle.
- R8: Each lane's `dec_pc` equals its chunk base plus 4 times its slot index, and `dec_instr` is the word read from that slot.
- R9: Without a redirect, two reads in consecutive cycles differ in address by 32. The instruction stream offered to decode has no gaps and no repeats.
- R10: While `rst_n` is low, `dec_valid` is zero. In the first cycle after release, a read is issued at the aligned reset address (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_valid | input | 1 | Restart fetch at `redirect_addr`, discarding queued work |
| redirect_addr | input | 32 | Word-aligned redirect target |
| refill_pending | input | 1 | A miss-refill write wants the cache port |
| port_rd | output | 1 | Cache read of one chunk this cycle |
| port_wr | output | 1 | Cache port granted to the refill write this cycle |
| port_addr | output | 32 | Aligned chunk address of the read |
| port_rdata | input | 256 | Chunk data, one cycle after `port_rd` |
| dec_stall | input | 1 | Decode takes nothing this cycle |
| dec_valid | output | 5 | Valid lanes toward decode |
| dec_instr | output | 160 | Lane instructions, lane l at [32l+31:32l] |
| dec_pc | output | 160 | Lane addresses, lane l at [32l+31:32l] |

## Verification
The bench targets targets in the middle and at the end of a chunk. A design that skipped trimming would offer stale slots first, and one that trimmed wrongly would offer the wrong number of instructions in the first cycle. A second redirect is issued while the first redirect's chunk is still in flight; a design that failed to cancel that chunk would let addresses from the abandoned stream leak into decode. Decode is stalled until the queue fills, to show that a design without the room check overruns the queue or keeps reading. A refill burst is placed in the middle of a running stream, to catch a design that lets the fetch win the port or that loses or repeats instructions when the fetch resumes.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
   localparam int unsigned BITS_PER_BYTE = 8;

   function automatic int unsigned lesser(int unsigned a, int unsigned b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/cfb_fetch_ctrl.sv
module cfb_fetch_ctrl #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SLOTS       = 8,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned WORD_LG     = 2,
   parameter int unsigned SLOT_LG     = 3,
   parameter int unsigned CNT_W       = 5,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               redirect_valid,
   input  logic [ADDR_W-1:0]  redirect_addr,
   input  logic               refill_pending,
   input  logic [CNT_W-1:0]   q_count,
   output logic               port_rd,
   output logic               port_wr,
   output logic [ADDR_W-1:0]  port_addr,
   output logic               wr_valid,
   output logic [ADDR_W-1:0]  wr_base,
   output logic [SLOT_LG-1:0] wr_start
);
   localparam int unsigned OFFS_LG  = WORD_LG + SLOT_LG;
   localparam int unsigned CHUNK_W  = ADDR_W - OFFS_LG;
   localparam int unsigned LIMIT    = DEPTH - SLOTS;
   localparam int unsigned CHUNK_BYTES = SLOTS << WORD_LG;

   logic [ADDR_W-1:WORD_LG] fpc_q;
   logic                    inflight_q;
   logic [ADDR_W-1:0]       base_q;
   logic [SLOT_LG-1:0]      start_q;
   logic [CNT_W:0]          committed;
   logic                    room;
   logic                    fetch_go;
   logic [ADDR_W-1:0]       aligned;

   assign aligned   = {fpc_q[ADDR_W-1:OFFS_LG], OFFS_LG'(0)};
   assign committed = (CNT_W+1)'(q_count) + (inflight_q ? (CNT_W+1)'(SLOTS) : '0);
   assign room      = committed <= (CNT_W+1)'(LIMIT);
   assign fetch_go  = !redirect_valid && !refill_pending && room;

   assign port_rd   = fetch_go;
   assign port_wr   = refill_pending;
   assign port_addr = aligned;
   assign wr_valid  = inflight_q && !redirect_valid;
   assign wr_base   = base_q;
   assign wr_start  = start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fpc_q      <= RESET_PC[ADDR_W-1:WORD_LG];
         inflight_q <= 1'b0;
         base_q     <= '0;
         start_q    <= '0;
      end else if (redirect_valid) begin
         fpc_q      <= redirect_addr[ADDR_W-1:WORD_LG];
         inflight_q <= 1'b0;
      end else begin
         inflight_q <= fetch_go;
         if (fetch_go) begin
            base_q  <= aligned;
            start_q <= fpc_q[OFFS_LG-1:WORD_LG];
            fpc_q   <= {fpc_q[ADDR_W-1:OFFS_LG] + CHUNK_W'(1), SLOT_LG'(0)};
         end
      end
   end

   assert_port_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      refill_pending |-> (port_wr && !port_rd));

   assert_target_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> (redirect_addr[WORD_LG-1:0] == '0));

   assert_seq_chunk_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (port_rd && $past(port_rd) && $past(rst_n))
         |-> (port_addr == $past(port_addr) + ADDR_W'(CHUNK_BYTES)));

   assert_redirect_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> !port_rd);
endmodule

// File: rtl/cfb_inst_queue.sv
module cfb_inst_queue #(
   parameter int unsigned INSTR_W    = 32,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned SLOTS      = 8,
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned LANES      = 5,
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned SLOT_LG    = 3,
   parameter int unsigned CNT_W      = 5,
   parameter int unsigned PTR_W      = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       wr_valid,
   input  logic [SLOTS*INSTR_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]          wr_base,
   input  logic [SLOT_LG-1:0]         wr_start,
   input  logic                       pop_block,
   output logic [CNT_W-1:0]           count,
   output logic [LANES-1:0]           lane_valid,
   output logic [LANES*INSTR_W-1:0]   lane_instr,
   output logic [LANES*ADDR_W-1:0]    lane_pc
);
   logic [INSTR_W-1:0] instr_mem [DEPTH];
   logic [ADDR_W-1:0]  pc_mem    [DEPTH];
   logic [PTR_W-1:0]   head_q, tail_q;
   logic [CNT_W-1:0]   count_q;
   logic [CNT_W-1:0]   wr_cnt, pop_cnt;

   assign wr_cnt  = wr_valid ? (CNT_W'(SLOTS) - CNT_W'(wr_start)) : '0;
   assign pop_cnt = (pop_block || flush) ? '0 :
                    ((count_q < CNT_W'(LANES)) ? count_q : CNT_W'(LANES));
   assign count   = count_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [PTR_W-1:0] rd_idx;
      assign rd_idx = head_q + PTR_W'(l);
      assign lane_valid[l] = !flush && (count_q > CNT_W'(l));
      assign lane_instr[l*INSTR_W +: INSTR_W] = instr_mem[rd_idx];
      assign lane_pc[l*ADDR_W +: ADDR_W]      = pc_mem[rd_idx];
   end

   always_ff @(posedge clk) begin
      for (int s = 0; s < SLOTS; s++) begin
         if (wr_valid && (s >= int'(wr_start))) begin
            instr_mem[tail_q + PTR_W'(s) - PTR_W'(wr_start)] <= wr_data[s*INSTR_W +: INSTR_W];
            pc_mem[tail_q + PTR_W'(s) - PTR_W'(wr_start)]    <= wr_base + ADDR_W'(s * WORD_BYTES);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         head_q  <= head_q + PTR_W'(pop_cnt);
         tail_q  <= tail_q + PTR_W'(wr_cnt);
         count_q <= count_q + wr_cnt - pop_cnt;
      end
   end

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |-> (({1'b0, count_q} + {1'b0, wr_cnt}) <= (CNT_W+1)'(DEPTH)));

   assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (lane_valid == '0) || flush);

   assert_lane_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid[1] |-> (lane_pc[2*ADDR_W-1:ADDR_W] == lane_pc[ADDR_W-1:0] + ADDR_W'(WORD_BYTES)));

   assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_block && lane_valid[0] && !flush) |=>
         (flush || (lane_valid[0] && lane_pc[ADDR_W-1:0] == $past(lane_pc[ADDR_W-1:0]))));
endmodule

// File: rtl/chunk_fetch_buffer.sv
module chunk_fetch_buffer #(
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned SLOTS   = 8,
   parameter int unsigned LANES   = 5,
   parameter int unsigned DEPTH   = 16,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     redirect_valid,
   input  logic [ADDR_W-1:0]        redirect_addr,
   input  logic                     refill_pending,
   output logic                     port_rd,
   output logic                     port_wr,
   output logic [ADDR_W-1:0]        port_addr,
   input  logic [SLOTS*INSTR_W-1:0] port_rdata,
   input  logic                     dec_stall,
   output logic [LANES-1:0]         dec_valid,
   output logic [LANES*INSTR_W-1:0] dec_instr,
   output logic [LANES*ADDR_W-1:0]  dec_pc
);
   import cfb_pkg::*;

   localparam int unsigned WORD_BYTES = INSTR_W / BITS_PER_BYTE;
   localparam int unsigned WORD_LG    = $clog2(WORD_BYTES);
   localparam int unsigned SLOT_LG    = $clog2(SLOTS);
   localparam int unsigned CNT_W      = $clog2(DEPTH + 1);
   localparam int unsigned PTR_W      = $clog2(DEPTH);
   localparam int unsigned MAX_LANES  = lesser(LANES, DEPTH);

   if (INSTR_W % BITS_PER_BYTE != 0 || (1 << WORD_LG) != WORD_BYTES) begin : g_bad_word
      $error("instruction width must be a power-of-two number of bytes");
   end
   if ((1 << SLOT_LG) != SLOTS || SLOTS < 2) begin : g_bad_slots
      $error("slots per chunk must be a power of two of at least 2");
   end
   if ((1 << PTR_W) != DEPTH || DEPTH < SLOTS) begin : g_bad_depth
      $error("queue depth must be a power of two holding at least one chunk");
   end
   if (MAX_LANES != LANES || LANES < 2) begin : g_bad_lanes
      $error("decode lanes must be at least 2 and no more than the queue depth");
   end

   logic [CNT_W-1:0]   q_count;
   logic               wr_valid;
   logic [ADDR_W-1:0]  wr_base;
   logic [SLOT_LG-1:0] wr_start;

   cfb_fetch_ctrl #(
      .ADDR_W  (ADDR_W),
      .SLOTS   (SLOTS),
      .DEPTH   (DEPTH),
      .WORD_LG (WORD_LG),
      .SLOT_LG (SLOT_LG),
      .CNT_W   (CNT_W),
      .RESET_PC(RESET_PC)
   ) i_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .redirect_valid(redirect_valid),
      .redirect_addr (redirect_addr),
      .refill_pending(refill_pending),
      .q_count       (q_count),
      .port_rd       (port_rd),
      .port_wr       (port_wr),
      .port_addr     (port_addr),
      .wr_valid      (wr_valid),
      .wr_base       (wr_base),
      .wr_start      (wr_start)
   );

   cfb_inst_queue #(
      .INSTR_W   (INSTR_W),
      .ADDR_W    (ADDR_W),
      .SLOTS     (SLOTS),
      .DEPTH     (DEPTH),
      .LANES     (LANES),
      .WORD_BYTES(WORD_BYTES),
      .SLOT_LG   (SLOT_LG),
      .CNT_W     (CNT_W),
      .PTR_W     (PTR_W)
   ) i_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (redirect_valid),
      .wr_valid  (wr_valid),
      .wr_data   (port_rdata),
      .wr_base   (wr_base),
      .wr_start  (wr_start),
      .pop_block (dec_stall),
      .count     (q_count),
      .lane_valid(dec_valid),
      .lane_instr(dec_instr),
      .lane_pc   (dec_pc)
   );

   assert_reset_quiet_R10: assert property (@(posedge clk)
      $past(!rst_n) |-> (dec_valid == '0));
endmodule

// File: tb/test_chunk_fetch_buffer.sv
`timescale 1ns/1ps
module test_chunk_fetch_buffer;
   localparam int unsigned LANES = 5;
   localparam int unsigned SLOTS = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         redirect_valid = 1'b0;
   logic [31:0]  redirect_addr = '0;
   logic         refill_pending = 1'b0;
   logic         port_rd, port_wr;
   logic [31:0]  port_addr;
   logic [255:0] port_rdata = '0;
   logic         dec_stall = 1'b0;
   logic [4:0]   dec_valid;
   logic [159:0] dec_instr, dec_pc;

   int errors = 0;
   int checks = 0;
   int log_n = 0;
   int rd_count = 0;
   bit done = 1'b0;
   logic [31:0] log_pc [0:255];

   always #4 clk = ~clk;

   chunk_fetch_buffer i_chunk_fetch_buffer (
      .clk(clk), .rst_n(rst_n),
      .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
      .refill_pending(refill_pending),
      .port_rd(port_rd), .port_wr(port_wr), .port_addr(port_addr),
      .port_rdata(port_rdata), .dec_stall(dec_stall),
      .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_pc(dec_pc)
   );

   function automatic logic [31:0] wordf(logic [31:0] a);
      return (a * 32'd2654435761) ^ 32'h0F0F_5A5A;
   endfunction

   // cache model, one-cycle read latency
   always @(posedge clk) begin
      if (port_rd) begin
         for (int k = 0; k < SLOTS; k++) port_rdata[k*32 +: 32] <= wordf(port_addr + 32'(4*k));
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: lane contents (R8), contiguity (R3), log of consumed addresses
   always @(negedge clk) begin
      if (rst_n) begin
         for (int l = 0; l < LANES; l++) begin
            if (dec_valid[l]) begin
               check(dec_instr[l*32 +: 32] == wordf(dec_pc[l*32 +: 32]), "R8 lane word",
                     dec_instr[l*32 +: 32], wordf(dec_pc[l*32 +: 32]));
               if (l > 0) check(dec_valid[l-1], "R3 contiguous lanes", 32'(dec_valid), 32'h1f);
               if (!dec_stall && log_n < 256) begin
                  log_pc[log_n] = dec_pc[l*32 +: 32];
                  log_n++;
               end
            end
         end
         if (port_rd) rd_count++;
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic redirect_to(input logic [31:0] a);
      redirect_valid = 1'b1;
      redirect_addr  = a;
      log_n    = 0;
      rd_count = 0;
      tick();
      redirect_valid = 1'b0;
   endtask

   task automatic seq_check(input logic [31:0] base, input int n, input string req);
      int bad = 0;
      logic [31:0] first_act = '0, first_exp = '0;
      for (int k = 0; k < n; k++) begin
         if (k >= log_n || log_pc[k] != base + 32'(4*k)) begin
            if (bad == 0) begin
               first_act = (k < log_n) ? log_pc[k] : 32'hFFFF_FFFF;
               first_exp = base + 32'(4*k);
            end
            bad++;
         end
      end
      check(bad == 0, req, first_act, first_exp);
   endtask

   // vectors: redirect target, lanes offered in first dispatch cycle
   localparam logic [31:0] VEC_TGT   [6] = '{32'h1000, 32'h2014, 32'h311C, 32'h4008, 32'h5018, 32'h6010};
   localparam int          VEC_FIRST [6] = '{5, 3, 1, 5, 2, 4};

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      // R10 reset state
      repeat (4) tick();
      @(negedge clk);
      check(dec_valid == '0, "R10 reset lanes idle", 32'(dec_valid), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      log_n = 0;
      @(negedge clk);
      check(port_rd && port_addr == 32'h0, "R10 first read at reset address", port_addr, 32'h0);
      repeat (16) tick();
      seq_check(32'h0, 24, "R9 sequential stream from reset");

      // R2 table of redirect targets
      for (int v = 0; v < 6; v++) begin
         redirect_to(VEC_TGT[v]);
         tick(); tick();
         @(negedge clk);
         check(dec_valid[0] && dec_pc[31:0] == VEC_TGT[v], "R2 first lane is target",
               dec_pc[31:0], VEC_TGT[v]);
         check($countones(dec_valid) == VEC_FIRST[v], "R2 first cycle lane count",
               32'($countones(dec_valid)), 32'(VEC_FIRST[v]));
         repeat (14) tick();
         seq_check(VEC_TGT[v], 24, "R9 continuous stream after redirect");
      end

      // R6 fill with decode stalled
      dec_stall = 1'b1;
      redirect_to(32'h8000);
      repeat (9) tick();
      @(negedge clk);
      check(rd_count == 2, "R6 reads while stalled", 32'(rd_count), 2);
      check(dec_valid == 5'h1f, "R3 five lanes offered", 32'(dec_valid), 32'h1f);
      check(dec_pc[159:128] == 32'h8010, "R3 lane 4 address", dec_pc[159:128], 32'h8010);
      @(posedge clk); #1;
      dec_stall = 1'b0;
      tick();
      dec_stall = 1'b1;
      @(negedge clk);
      check(dec_pc[31:0] == 32'h8014, "R4 leftover moves to lane 0", dec_pc[31:0], 32'h8014);
      tick();
      @(negedge clk);
      check(dec_valid[0] && dec_pc[31:0] == 32'h8014, "R4 held while stalled", dec_pc[31:0], 32'h8014);
      check(rd_count == 2, "R6 no read above limit", 32'(rd_count), 2);

      // R7 redirect flush in the same cycle
      @(posedge clk); #1;
      redirect_valid = 1'b1;
      redirect_addr  = 32'h9000;
      @(negedge clk);
      check(dec_valid == '0, "R7 lanes cleared in redirect cycle", 32'(dec_valid), 0);
      check(!port_rd, "R7 no read in redirect cycle", 32'(port_rd), 0);
      @(posedge clk); #1;
      redirect_valid = 1'b0;
      @(negedge clk);
      check(dec_valid == '0, "R7 queue empty after redirect", 32'(dec_valid), 0);
      tick();
      @(negedge clk);
      check(dec_valid == '0, "R7 idle second cycle", 32'(dec_valid), 0);
      tick();
      @(negedge clk);
      check(dec_valid[0] && dec_pc[31:0] == 32'h9000, "R7 target three cycles later", dec_pc[31:0], 32'h9000);
      @(posedge clk); #1;
      dec_stall = 1'b0;

      // R7 in-flight chunk cancelled by second redirect
      redirect_to(32'hA000);
      tick();
      redirect_to(32'hB040);
      repeat (14) tick();
      begin
         int leak = 0;
         for (int k = 0; k < log_n; k++) if (log_pc[k][31:5] == 27'(32'hA000 >> 5)) leak++;
         check(leak == 0, "R7 abandoned chunk dropped", 32'(leak), 0);
      end
      seq_check(32'hB040, 24, "R7 stream follows second target");

      // R5 refill priority
      redirect_to(32'hC000);
      refill_pending = 1'b1;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         check(port_wr && !port_rd, "R5 refill owns port", {30'b0, port_wr, port_rd}, 32'h2);
         @(posedge clk); #1;
      end
      refill_pending = 1'b0;
      repeat (16) tick();
      seq_check(32'hC000, 24, "R5 stream intact after refill");
      check(log_n > 24, "R1 chunk data delivered", 32'(log_n), 25);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule